// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings one switchable logic domain up or down in a fixed, safe order. On a request it walks the domain's power switches, clock gate, isolation cells, domain reset, SRAM power-down lines and bus fence through a strict sequence. Every step that depends on the outside world waits for the matching acknowledge. Each acknowledge is sampled on a slow poll tick, and the whole wait gives up after a bounded number of polls.

Software starts a sequence with a one-cycle `req_go` and chooses the direction with `req_on`. The mode inputs are captured at that moment and held for the rest of the sequence: the SRAM line mask, the SRAM acknowledge mask, forced-wait mode and bus-fence enable. The block reports `busy` while a sequence runs, a one-cycle `done` when it finishes, and a sticky `timeout_err` when a wait expires. The domain status is three-valued and comes from the two power acknowledges. `dom_on` and `dom_off` are both low while those acknowledges disagree.

Timing is set in clock cycles through `CYCLES_PER_US`, which scales three values: the 10 µs poll interval, the 1 s wait limit and the 12 ms forced SRAM wait.

Top module: `pd_sequencer`

## Requirements
- R1: After reset the domain is held fully off. `pd_ctl` = 5'b10010, where bit0 is the active-low reset, bit1 isolation, bit2 primary power enable, bit3 secondary power enable and bit4 clock disable. `sram_pdn` is all ones, `bus_prot_req` = 1, and `busy`, `done` and `timeout_err` are 0.
- R2: Power-up changes exactly one thing per step, in this order:
  - set bit2, then set bit3;
  - wait until both power acknowledges are high;
  - clear bit4, then clear bit1, then set bit0;
  - clear the masked `sram_pdn` lines and wait for the SRAM handshake;
  - if the fence is enabled, drop `bus_prot_req` and wait until `bus_prot_ack` is low.
- R3: Power-down runs in this order:
  - if the fence is enabled, raise `bus_prot_req` and wait until `bus_prot_ack` is high;
  - set the masked `sram_pdn` lines and wait for the SRAM handshake;
  - set bit1, then clear bit0, then set bit4;
  - clear bit2, then clear bit3;
  - wait until both power acknowledges are low.
- R4: `dom_on` is 1 only when both power acknowledges are high. `dom_off` is 1 only when both are low. When the two acknowledges differ, both outputs are 0.
- R5: The SRAM handshake passes on power-up when every `sram_ack` bit selected by the acknowledge mask reads 0. On power-down it passes when every selected bit reads 1. With a zero acknowledge mask it passes at the first poll. Only the `sram_pdn` lines selected by the line mask move.
- R6: In forced-wait mode, power-up does not poll the SRAM acknowledge. It waits a fixed FWAIT_US × CYCLES_PER_US cycles after clearing the SRAM lines, so it completes even when `sram_ack` never falls.
- R7: With the fence disabled, `bus_prot_req` does not change during either sequence.
- R8: A wait that sees no acknowledge within TIMEOUT_US/POLL_US polls does the following:
  - sets `timeout_err` and returns to idle without `done`;
  - leaves all outputs at their last values;
  - keeps `timeout_err` set until `err_clr` is pulsed.
- R9: A request made while a sequence is running, or while `timeout_err` is set, is ignored.
- R10: A request for the state the domain is already in gives `done` on the first edge after `req_go` and changes no output.
- R11: `done` is a single-cycle pulse that only occurs with `busy` low. `busy` is high for the whole of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_go | input | 1 | One-cycle request strobe |
| req_on | input | 1 | Target state: 1 = up, 0 = down |
| cfg_sram_mask | input | SRAM_W | SRAM lines this domain uses |
| cfg_ack_mask | input | SRAM_W | SRAM acknowledge bits to wait on |
| cfg_fwait | input | 1 | Fixed delay instead of SRAM acknowledge on power-up |
| cfg_bus_prot | input | 1 | Enable the bus-fence steps |
| err_clr | input | 1 | Clear the sticky timeout flag |
| pwr_ack | input | 1 | Primary power switch acknowledge |
| pwr_ack2 | input | 1 | Secondary power switch acknowledge |
| sram_ack | input | SRAM_W | SRAM power-down acknowledges |
| bus_prot_ack | input | 1 | Bus fence acknowledge |
| pd_ctl | output | 5 | Domain control word (bit map in R1) |
| sram_pdn | output | SRAM_W | SRAM power-down lines |
| bus_prot_req | output | 1 | Bus fence request |
| done | output | 1 | Sequence complete pulse |
| busy | output | 1 | Sequence in progress |
| dom_on | output | 1 | Both power acknowledges high |
| dom_off | output | 1 | Both power acknowledges low |
| timeout_err | output | 1 | Sticky wait-timeout flag |

## Verification
The action steps move one output per clock edge. The waits, however, resolve only on a poll tick, so the exact cycle of each later step depends on the acknowledge latency and on the tick phase. The bench therefore compares the order of every change of the packed {`bus_prot_req`, `sram_pdn`, `pd_ctl`} word with a queue filled by the driver, and does not compare absolute cycles.

Three results are checked against fixed cycles:
- An immediate completion must show `done` at the first falling edge after the request edge.
- `done` must be low again one cycle later.
- The forced-wait gap must lie between FWAIT cycles and a few cycles more, measured from the SRAM change to the fence drop.

Timeouts are awaited in a bounded loop, and the held outputs are then re-sampled after a pause.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

    // bit positions of the domain control word
    localparam int CTL_RSTN = 0;
    localparam int CTL_ISO  = 1;
    localparam int CTL_PWR1 = 2;
    localparam int CTL_PWR2 = 3;
    localparam int CTL_CKD  = 4;

    localparam logic [4:0] CTL_OFF = 5'b10010;

    typedef enum logic [4:0] {
        S_IDLE,
        S_U_PWR1, S_U_PWR2, S_U_WPWR, S_U_CLK, S_U_ISO, S_U_RST,
        S_U_SRAM, S_U_WSRAM, S_U_FWAIT, S_U_BP, S_U_WBP,
        S_D_BP, S_D_WBP, S_D_SRAM, S_D_WSRAM, S_D_ISO, S_D_RST,
        S_D_CLK, S_D_PWR1, S_D_PWR2, S_D_WPWR
    } seq_state_e;

endpackage

// File: rtl/pd_poll_tick.sv
module pd_poll_tick #(
    parameter int PERIOD = 500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    generate
        if (PERIOD <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                   cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/pd_pwr_status.sv
module pd_pwr_status (
    input  logic ack_a,
    input  logic ack_b,
    output logic is_on,
    output logic is_off
);
    // a disagreement between the switches means a transition: neither flag
    assign is_on  = ack_a & ack_b;
    assign is_off = ~ack_a & ~ack_b;
endmodule

// File: rtl/pd_sram_ack_eval.sv
module pd_sram_ack_eval #(
    parameter int W = 4
) (
    input  logic [W-1:0] ack,
    input  logic [W-1:0] mask,
    output logic         all_low,
    output logic         all_high
);
    assign all_low  = ((ack & mask) == '0);
    assign all_high = ((ack & mask) == mask);
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
    import pd_seq_pkg::*;
#(
    parameter int CYCLES_PER_US = 50,
    parameter int POLL_US       = 10,
    parameter int TIMEOUT_US    = 1000000,
    parameter int FWAIT_US      = 12000,
    parameter int SRAM_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_go,
    input  logic              req_on,
    input  logic [SRAM_W-1:0] cfg_sram_mask,
    input  logic [SRAM_W-1:0] cfg_ack_mask,
    input  logic              cfg_fwait,
    input  logic              cfg_bus_prot,
    input  logic              err_clr,
    input  logic              pwr_ack,
    input  logic              pwr_ack2,
    input  logic [SRAM_W-1:0] sram_ack,
    input  logic              bus_prot_ack,
    output logic [4:0]        pd_ctl,
    output logic [SRAM_W-1:0] sram_pdn,
    output logic              bus_prot_req,
    output logic              done,
    output logic              busy,
    output logic              dom_on,
    output logic              dom_off,
    output logic              timeout_err
);
    localparam int POLL_CYC  = CYCLES_PER_US * POLL_US;
    localparam int TO_POLLS  = (TIMEOUT_US / POLL_US > 1) ? TIMEOUT_US / POLL_US : 1;
    localparam int FW_CYC    = (CYCLES_PER_US * FWAIT_US > 1) ? CYCLES_PER_US * FWAIT_US : 1;
    localparam int PW        = $clog2(TO_POLLS + 1);
    localparam int FW        = $clog2(FW_CYC + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(TO_POLLS - 1);
    localparam logic [FW-1:0] FW_LOAD   = FW'(FW_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [4:0]        ctl;
        logic [SRAM_W-1:0] sram;
        logic              bp;
        logic              done;
        logic              err;
        logic [PW-1:0]     polls;
        logic [FW-1:0]     fwc;
        logic [SRAM_W-1:0] m_sram;
        logic [SRAM_W-1:0] m_ack;
        logic              fwait;
        logic              bpen;
    } seq_t;

    seq_t q, d;

    logic tick, st_on, st_off, sr_low, sr_high;
    logic       wait_st, cond;
    seq_state_e nxt;

    pd_poll_tick #(.PERIOD(POLL_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    pd_pwr_status u_stat (
        .ack_a(pwr_ack), .ack_b(pwr_ack2), .is_on(st_on), .is_off(st_off)
    );

    pd_sram_ack_eval #(.W(SRAM_W)) u_sram (
        .ack(sram_ack), .mask(q.m_ack), .all_low(sr_low), .all_high(sr_high)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        wait_st = 1'b0;
        cond    = 1'b0;
        nxt     = q.st;
        if (err_clr) d.err = 1'b0;
        case (q.st)
            S_IDLE: if (req_go && !q.err) begin
                d.m_sram = cfg_sram_mask;
                d.m_ack  = cfg_ack_mask;
                d.fwait  = cfg_fwait;
                d.bpen   = cfg_bus_prot;
                d.polls  = '0;
                if (req_on) begin
                    if (st_on) d.done = 1'b1;
                    else       d.st   = S_U_PWR1;
                end else begin
                    if (st_off)            d.done = 1'b1;
                    else if (cfg_bus_prot) d.st   = S_D_BP;
                    else                   d.st   = S_D_SRAM;
                end
            end
            // ---- power-up ----
            S_U_PWR1:  begin d.ctl[CTL_PWR1] = 1'b1; d.st = S_U_PWR2; end
            S_U_PWR2:  begin d.ctl[CTL_PWR2] = 1'b1; d.st = S_U_WPWR; end
            S_U_WPWR:  begin wait_st = 1'b1; cond = st_on; nxt = S_U_CLK; end
            S_U_CLK:   begin d.ctl[CTL_CKD]  = 1'b0; d.st = S_U_ISO; end
            S_U_ISO:   begin d.ctl[CTL_ISO]  = 1'b0; d.st = S_U_RST; end
            S_U_RST:   begin d.ctl[CTL_RSTN] = 1'b1; d.st = S_U_SRAM; end
            S_U_SRAM: begin
                d.sram = q.sram & ~q.m_sram;
                d.fwc  = FW_LOAD;
                d.st   = q.fwait ? S_U_FWAIT : S_U_WSRAM;
            end
            S_U_WSRAM: begin wait_st = 1'b1; cond = sr_low;
                             nxt = q.bpen ? S_U_BP : S_IDLE; end
            S_U_FWAIT: begin
                if (q.fwc == '0) d.st  = q.bpen ? S_U_BP : S_IDLE;
                else             d.fwc = q.fwc - 1'b1;
                if (q.fwc == '0 && !q.bpen) d.done = 1'b1;
            end
            S_U_BP:    begin d.bp = 1'b0; d.st = S_U_WBP; end
            S_U_WBP:   begin wait_st = 1'b1; cond = !bus_prot_ack; nxt = S_IDLE; end
            // ---- power-down ----
            S_D_BP:    begin d.bp = 1'b1; d.st = S_D_WBP; end
            S_D_WBP:   begin wait_st = 1'b1; cond = bus_prot_ack; nxt = S_D_SRAM; end
            S_D_SRAM:  begin d.sram = q.sram | q.m_sram; d.st = S_D_WSRAM; end
            S_D_WSRAM: begin wait_st = 1'b1; cond = sr_high; nxt = S_D_ISO; end
            S_D_ISO:   begin d.ctl[CTL_ISO]  = 1'b1; d.st = S_D_RST; end
            S_D_RST:   begin d.ctl[CTL_RSTN] = 1'b0; d.st = S_D_CLK; end
            S_D_CLK:   begin d.ctl[CTL_CKD]  = 1'b1; d.st = S_D_PWR1; end
            S_D_PWR1:  begin d.ctl[CTL_PWR1] = 1'b0; d.st = S_D_PWR2; end
            S_D_PWR2:  begin d.ctl[CTL_PWR2] = 1'b0; d.st = S_D_WPWR; end
            S_D_WPWR:  begin wait_st = 1'b1; cond = st_off; nxt = S_IDLE; end
            default:   d.st = S_IDLE;
        endcase

        if (wait_st && tick) begin
            if (cond) begin
                d.st    = nxt;
                d.polls = '0;
                if (nxt == S_IDLE) d.done = 1'b1;
            end else if (q.polls == POLL_LAST) begin
                d.err   = 1'b1;
                d.st    = S_IDLE;
                d.polls = '0;
            end else begin
                d.polls = q.polls + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.ctl    <= CTL_OFF;
            q.sram   <= '1;
            q.bp     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pd_ctl       = q.ctl;
    assign sram_pdn     = q.sram;
    assign bus_prot_req = q.bp;
    assign done         = q.done;
    assign busy         = (q.st != S_IDLE);
    assign dom_on       = st_on;
    assign dom_off      = st_off;
    assign timeout_err  = q.err;
endmodule

// File: rtl/pd_sequencer_chk.sv
module pd_sequencer_chk #(
    parameter int SRAM_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        pd_ctl,
    input logic [SRAM_W-1:0] sram_pdn,
    input logic              bus_prot_req,
    input logic              done,
    input logic              busy,
    input logic              dom_on,
    input logic              dom_off,
    input logic              timeout_err,
    input logic              err_clr
);
    // clock runs only while both switches are enabled
    assert_clk_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_ctl[4] |-> (pd_ctl[2] && pd_ctl[3]));

    // isolation released only after the clock is running
    assert_iso_after_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_ctl[1] |-> !pd_ctl[4]);

    // SRAM lines powered only while the domain is out of reset
    assert_sram_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_pdn != '1) |-> pd_ctl[0]);

    // fence dropped only while the domain is out of reset
    assert_fence_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_prot_req |-> pd_ctl[0]);

    assert_status_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dom_on && dom_off));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && !err_clr) |=> timeout_err);

    assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!busy && !done));
endmodule

bind pd_sequencer pd_sequencer_chk #(.SRAM_W(SRAM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pd_ctl(pd_ctl), .sram_pdn(sram_pdn),
    .bus_prot_req(bus_prot_req), .done(done), .busy(busy),
    .dom_on(dom_on), .dom_off(dom_off), .timeout_err(timeout_err),
    .err_clr(err_clr)
);

// File: tb/pd_sequencer_test.sv
module pd_sequencer_test;
    localparam int SW = 4;
    localparam int FW_CYC = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_go = 1'b0, req_on = 1'b0;
    logic [SW-1:0] cfg_sram_mask = 4'hF, cfg_ack_mask = 4'hF;
    logic cfg_fwait = 1'b0, cfg_bus_prot = 1'b1, err_clr = 1'b0;
    logic pwr_ack, pwr_ack2, bus_prot_ack;
    logic [SW-1:0] sram_ack;
    logic [4:0] pd_ctl;
    logic [SW-1:0] sram_pdn;
    logic bus_prot_req, done, busy, dom_on, dom_off, timeout_err;

    always #10 clk = ~clk;

    pd_sequencer #(
        .CYCLES_PER_US(1), .POLL_US(2), .TIMEOUT_US(60), .FWAIT_US(FW_CYC), .SRAM_W(SW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_on(req_on),
        .cfg_sram_mask(cfg_sram_mask), .cfg_ack_mask(cfg_ack_mask),
        .cfg_fwait(cfg_fwait), .cfg_bus_prot(cfg_bus_prot), .err_clr(err_clr),
        .pwr_ack(pwr_ack), .pwr_ack2(pwr_ack2), .sram_ack(sram_ack),
        .bus_prot_ack(bus_prot_ack), .pd_ctl(pd_ctl), .sram_pdn(sram_pdn),
        .bus_prot_req(bus_prot_req), .done(done), .busy(busy),
        .dom_on(dom_on), .dom_off(dom_off), .timeout_err(timeout_err)
    );

    // ---- plant: acknowledges follow the requests after three cycles ----
    logic [2:0] d_p1 = '0, d_p2 = '0, d_bp = '1;
    logic [SW-1:0] d_s0 = '1, d_s1 = '1, d_s2 = '1;
    logic hold_ack2_low = 1'b0, sram_stuck = 1'b0;
    always @(posedge clk) begin
        d_p1 <= {d_p1[1:0], pd_ctl[2]};
        d_p2 <= {d_p2[1:0], pd_ctl[3]};
        d_bp <= {d_bp[1:0], bus_prot_req};
        d_s0 <= sram_pdn; d_s1 <= d_s0; d_s2 <= d_s1;
    end
    assign pwr_ack      = d_p1[2];
    assign pwr_ack2     = d_p2[2] & ~hold_ack2_low;
    assign bus_prot_ack = d_bp[2];
    assign sram_ack     = sram_stuck ? '1 : d_s2;

    // ---- scoreboard ----
    int checks = 0, errors = 0, cyc = 0, done_cnt = 0;
    logic [9:0] exp_q[$];
    int chg_cyc[$];
    logic [9:0] exp_snap = {1'b1, 4'hF, 5'b10010};
    logic [9:0] last_snap = {1'b1, 4'hF, 5'b10010};
    logic mon_en = 1'b0;

    function automatic logic [9:0] snap();
        return {bus_prot_req, sram_pdn, pd_ctl};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (done) done_cnt++;
        if (mon_en && snap() != last_snap) begin
            chg_cyc.push_back(cyc);
            if (exp_q.size() == 0)
                chk(1'b0, "R2/R3", "unexpected output change", 32'(snap()), 32'(last_snap));
            else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk(snap() == e, "R2/R3", "step order", 32'(snap()), 32'(e));
            end
            last_snap = snap();
        end
    end

    function automatic void step(input logic [9:0] s);
        if (s != exp_snap) begin
            exp_q.push_back(s);
            exp_snap = s;
        end
    endfunction

    function automatic void plan_up(input logic [SW-1:0] m, input bit bpen);
        logic [9:0] s;
        s = exp_snap;
        s[2] = 1'b1; step(s);
        s[3] = 1'b1; step(s);
        s[4] = 1'b0; step(s);
        s[1] = 1'b0; step(s);
        s[0] = 1'b1; step(s);
        s[8:5] = s[8:5] & ~m; step(s);
        if (bpen) begin s[9] = 1'b0; step(s); end
    endfunction

    function automatic void plan_down(input logic [SW-1:0] m, input bit bpen);
        logic [9:0] s;
        s = exp_snap;
        if (bpen) begin s[9] = 1'b1; step(s); end
        s[8:5] = s[8:5] | m; step(s);
        s[1] = 1'b1; step(s);
        s[0] = 1'b0; step(s);
        s[4] = 1'b1; step(s);
        s[2] = 1'b0; step(s);
        s[3] = 1'b0; step(s);
    endfunction

    task automatic pulse_go(input bit on);
        @(negedge clk);
        req_on = on; req_go = 1'b1;
        @(negedge clk);
        req_go = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        chk(done, req, "done seen", 32'(done), 32'd1);
        chk(!busy, "R11", "busy low with done", 32'(busy), 32'd0);
        @(negedge clk);
        chk(!done, "R11", "done one cycle", 32'(done), 32'd0);
        chk(exp_q.size() == 0, req, "all steps seen", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic run(input bit on, input logic [SW-1:0] m, input logic [SW-1:0] am,
                       input bit fw, input bit bpen, input string req);
        cfg_sram_mask = m; cfg_ack_mask = am; cfg_fwait = fw; cfg_bus_prot = bpen;
        if (on) plan_up(m, bpen); else plan_down(m, bpen);
        pulse_go(on);
        wait_done(req);
        repeat (5) @(negedge clk);
        if (on) chk(dom_on,  req, "domain on",  32'(dom_on),  32'd1);
        else    chk(dom_off, req, "domain off", 32'(dom_off), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int dc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(snap() == 10'b1_1111_10010, "R1", "reset outputs", 32'(snap()), 32'h3F2);
        chk(!busy && !done && !timeout_err, "R1", "reset flags",
            32'({busy, done, timeout_err}), 32'd0);
        chk(dom_off && !dom_on, "R4", "off status at reset", 32'({dom_on, dom_off}), 32'd1);
        mon_en = 1'b1;

        // R10 request off while off
        pulse_go(1'b0);
        chk(done, "R10", "immediate done", 32'(done), 32'd1);
        @(negedge clk);
        chk(!done && !busy, "R10", "no sequence", 32'({done, busy}), 32'd0);

        // R2 full power-up, R3 power-down
        run(1'b1, 4'hF, 4'hF, 1'b0, 1'b1, "R2");
        pulse_go(1'b1);
        chk(done, "R10", "immediate done when on", 32'(done), 32'd1);
        repeat (5) @(negedge clk);
        run(1'b0, 4'hF, 4'hF, 1'b0, 1'b1, "R3");

        // R7 and R5: narrow mask, fence disabled
        run(1'b1, 4'h3, 4'h3, 1'b0, 1'b0, "R7");
        chk(sram_pdn == 4'hC, "R5", "only masked lines cleared", 32'(sram_pdn), 32'hC);
        chk(bus_prot_req, "R7", "fence untouched", 32'(bus_prot_req), 32'd1);
        run(1'b0, 4'h3, 4'h3, 1'b0, 1'b0, "R7");

        // R6 forced wait with a silent SRAM
        sram_stuck = 1'b1;
        run(1'b1, 4'hF, 4'hF, 1'b1, 1'b1, "R6");
        begin
            int g;
            g = chg_cyc[chg_cyc.size()-1] - chg_cyc[chg_cyc.size()-2];
            chk(g >= FW_CYC && g <= FW_CYC + 6, "R6", "forced wait gap", 32'(g), FW_CYC);
        end
        chk(!timeout_err, "R6", "no timeout", 32'(timeout_err), 32'd0);
        run(1'b0, 4'hF, 4'hF, 1'b0, 1'b1, "R3");

        // R5 zero acknowledge mask with a silent SRAM
        run(1'b1, 4'hF, 4'h0, 1'b0, 1'b1, "R5");
        sram_stuck = 1'b0;
        run(1'b0, 4'hF, 4'hF, 1'b0, 1'b1, "R3");

        // R9 request during a running sequence
        cfg_sram_mask = 4'hF; cfg_ack_mask = 4'hF; cfg_fwait = 1'b0; cfg_bus_prot = 1'b1;
        plan_up(4'hF, 1'b1);
        pulse_go(1'b1);
        chk(busy, "R11", "busy during sequence", 32'(busy), 32'd1);
        pulse_go(1'b0);
        chk(busy, "R9", "still busy after ignored request", 32'(busy), 32'd1);
        wait_done("R9");
        repeat (5) @(negedge clk);
        chk(dom_on, "R9", "ended up on", 32'(dom_on), 32'd1);
        run(1'b0, 4'hF, 4'hF, 1'b0, 1'b1, "R3");

        // R8 timeout with one switch silent, R4 transition status
        hold_ack2_low = 1'b1;
        begin
            logic [9:0] s;
            s = exp_snap; s[2] = 1'b1; step(s); s[3] = 1'b1; step(s);
        end
        dc = done_cnt;
        pulse_go(1'b1);
        repeat (10) @(negedge clk);
        chk(!dom_on && !dom_off, "R4", "transition status", 32'({dom_on, dom_off}), 32'd0);
        begin
            int n;
            n = 0;
            while (!timeout_err && n < 1000) begin @(negedge clk); n++; end
        end
        chk(timeout_err, "R8", "timeout raised", 32'(timeout_err), 32'd1);
        chk(!busy, "R8", "idle after timeout", 32'(busy), 32'd0);
        chk(done_cnt == dc, "R8", "no done on timeout", 32'(done_cnt - dc), 32'd0);
        repeat (20) @(negedge clk);
        chk(snap() == 10'b1_1111_11110, "R8", "outputs held", 32'(snap()), 32'h3FE);
        pulse_go(1'b0);
        repeat (10) @(negedge clk);
        chk(!busy && timeout_err, "R9", "request ignored under error",
            32'({busy, timeout_err}), 32'd1);
        chk(snap() == 10'b1_1111_11110, "R9", "no change under error", 32'(snap()), 32'h3FE);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(!timeout_err, "R8", "error cleared", 32'(timeout_err), 32'd0);
        hold_ack2_low = 1'b0;
        repeat (6) @(negedge clk);
        run(1'b0, 4'hF, 4'hF, 1'b0, 1'b1, "R8");

        chk(exp_q.size() == 0, "R2", "queue empty at end", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule